// File: doc/BRIEF.md
# Horizontal Character-Line Timing Generator

This block produces the horizontal timing for one row of a 24-character on-screen text overlay. Its clock is a pixel clock running at 384 times the line rate, so one horizontal line spans 384 clocks. Each falling edge of the horizontal flyback input starts a line. The block then waits for a programmable number of pixel clocks, which sets the horizontal position of the text. After that wait it opens an active window and drives two indices: which character is being drawn and which dot within it. It also pulses a load strobe that tells an external 12-bit pixel shift register to take the next glyph row.

The position code and the double-width bit are captured on the flyback falling edge and hold for the whole line. In double-width mode every dot lasts two pixel clocks, so each character takes 24 clocks instead of 12. The window closes after the 24th character, or when the line reaches its 384th clock, whichever comes first.

The control is a four-state machine:
- `ST_IDLE` is the state after reset, before any flyback edge.
- `ST_DELAY` counts the position delay.
- `ST_ACTIVE` is the open window.
- `ST_DONE` is the blank tail of the line.

The transitions are:
- Any state goes to `ST_DELAY` on a flyback falling edge. This one has priority over all others.
- `ST_DELAY` goes to `ST_ACTIVE` when the line count reaches the delay.
- `ST_ACTIVE` goes to `ST_DONE` on the last dot of character 23, or when the line count reaches 383.
- `ST_IDLE` and `ST_DONE` otherwise hold.

Top module: `hosd_htiming`

## Requirements
- R1: While reset is asserted and after its release, before any flyback falling edge, `win_active` and `sr_load` are 0.
- R2: Let E0 be the clock edge that first samples `hflb` low after it was sampled high. With D = `hpos`*6+61, `win_active` is 1 after edge E0+k exactly for D <= k < D+W, where W is 288 in normal mode and 576 in double-width mode. This holds as long as the R8 limit is not reached first.
- R3: `hpos` and `dbl_wide` are captured at E0. Changing them later in the line has no effect on that line's window or indices.
- R4: In normal mode, with offset o = k-D inside the window, `dot_idx` = o mod 12 and `char_idx` = o div 12.
- R5: In double-width mode, `dot_idx` = (o div 2) mod 12 and `char_idx` = o div 24.
- R6: `sr_load` is 1 exactly on the last clock of dot 11 of each character inside the window. In normal mode that is o mod 12 = 11; in double-width mode it is o mod 24 = 23. The following clock shows dot 0, or the window is closed.
- R7: The window closes after character 23 has been emitted. With a small delay, no more than 24 characters are ever shown.
- R8: The window is never open at or after line count 384 (k >= 384). A late start or a double-width line is cut short there.
- R9: A flyback falling edge while the window is open closes it from the next clock and restarts the delay with newly captured settings.
- R10: After the window closes, it stays closed until the next flyback falling edge, no matter how long `hflb` stays low or high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, 384 per line |
| rst_n | input | 1 | Active-low synchronous reset |
| hflb | input | 1 | Horizontal flyback; its falling edge starts a line |
| hpos | input | 5 | Horizontal position code, delay = hpos*6+61 clocks |
| dbl_wide | input | 1 | 1 selects double-width characters |
| win_active | output | 1 | High while the character window is open |
| char_idx | output | 5 | Character index within the row, 0 to 23 |
| dot_idx | output | 4 | Dot index within the character, 0 to 11 |
| sr_load | output | 1 | Load strobe for the 12-bit pixel shift register |

## Verification
The assertions take for granted that `hflb` is a clean level, synchronous to the pixel clock, so that one sampled high-to-low change marks exactly one line start. They also take for granted that the flyback pulse lasts at least one clock. The line-limit check counts clocks from that sampled edge on its own, so it relies on the pixel clock being steady within a line. The stimulus drives every input a fixed time after the rising edge. Each flyback pulse is exactly one clock high, and the settings change only well inside a line, never in the clock that captures them.

// File: rtl/hosd_pkg.sv
package hosd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_ACTIVE,
        ST_DONE
    } hst_t;
endpackage

// File: rtl/hosd_edge.sv
module hosd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    assign fall = prev_q & ~sig;
endmodule

// File: rtl/hosd_linecnt.sv
module hosd_linecnt #(
    parameter int LINE = 384,
    parameter int LW   = $clog2(LINE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [LW-1:0] cnt
);
    localparam logic [LW-1:0] CAP = LW'(LINE - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= CAP;
        else if (clr)        cnt <= '0;
        else if (cnt != CAP) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hosd_dotgen.sv
module hosd_dotgen #(
    parameter int DOTS  = 12,
    parameter int CHARS = 24,
    parameter int DW    = $clog2(DOTS),
    parameter int CW    = $clog2(CHARS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          dbl,
    output logic [DW-1:0] dot,
    output logic [CW-1:0] chr,
    output logic          last_dot,
    output logic          last_char
);
    logic sub_q;
    logic step;

    assign step      = ~dbl | sub_q;
    assign last_dot  = step & (dot == DW'(DOTS - 1));
    assign last_char = last_dot & (chr == CW'(CHARS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sub_q <= 1'b0;
            dot   <= '0;
            chr   <= '0;
        end else begin
            sub_q <= dbl & ~sub_q;
            if (last_dot) begin
                dot <= '0;
                chr <= chr + 1'b1;
            end else if (step) begin
                dot <= dot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hosd_htiming.sv
module hosd_htiming #(
    parameter int LINE  = 384,
    parameter int DOTS  = 12,
    parameter int CHARS = 24,
    parameter int PW    = 5,
    parameter int STEP  = 6,
    parameter int BASE  = 61
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hflb,
    input  logic [PW-1:0]            hpos,
    input  logic                     dbl_wide,
    output logic                     win_active,
    output logic [$clog2(CHARS)-1:0] char_idx,
    output logic [$clog2(DOTS)-1:0]  dot_idx,
    output logic                     sr_load
);
    import hosd_pkg::*;

    localparam int LW = $clog2(LINE);
    localparam int DW = $clog2(DOTS);
    localparam int CW = $clog2(CHARS);

    hst_t          state_q, state_d;
    logic          fall;
    logic [LW-1:0] line_cnt;
    logic [LW-1:0] delay_end;
    logic [PW-1:0] hpos_q;
    logic          dbl_q;
    logic [DW-1:0] dot;
    logic [CW-1:0] chr;
    logic          last_dot, last_char;

    hosd_edge u_edge (
        .clk (clk),
        .rst_n (rst_n),
        .sig (hflb),
        .fall (fall)
    );

    hosd_linecnt #(.LINE(LINE), .LW(LW)) u_line (
        .clk (clk),
        .rst_n (rst_n),
        .clr (fall),
        .cnt (line_cnt)
    );

    hosd_dotgen #(.DOTS(DOTS), .CHARS(CHARS), .DW(DW), .CW(CW)) u_dots (
        .clk (clk),
        .rst_n (rst_n),
        .run (state_q == ST_ACTIVE),
        .dbl (dbl_q),
        .dot (dot),
        .chr (chr),
        .last_dot (last_dot),
        .last_char (last_char)
    );

    // settings captured on the line-start edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos_q <= '0;
            dbl_q  <= 1'b0;
        end else if (fall) begin
            hpos_q <= hpos;
            dbl_q  <= dbl_wide;
        end
    end

    assign delay_end = LW'(int'(hpos_q) * STEP + BASE - 1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (fall) begin
            state_d = ST_DELAY;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_DELAY:  if (line_cnt == delay_end) state_d = ST_ACTIVE;
                ST_ACTIVE: if (last_char || line_cnt == LW'(LINE - 1))
                               state_d = ST_DONE;
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        win_active = (state_q == ST_ACTIVE);
        sr_load    = win_active & last_dot;
        char_idx   = chr;
        dot_idx    = dot;
    end
endmodule

// File: rtl/hosd_chk.sv
module hosd_chk #(
    parameter int LINE  = 384,
    parameter int DOTS  = 12,
    parameter int CHARS = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     hflb,
    input logic                     win_active,
    input logic [$clog2(CHARS)-1:0] char_idx,
    input logic [$clog2(DOTS)-1:0]  dot_idx,
    input logic                     sr_load
);
    localparam int CNW = $clog2(LINE) + 1;
    localparam logic [CNW-1:0] CAP = {CNW{1'b1}};

    logic           h_prev;
    logic [CNW-1:0] since_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_prev     <= 1'b0;
            since_fall <= CAP;
        end else begin
            h_prev <= hflb;
            if (h_prev && !hflb)     since_fall <= '0;
            else if (since_fall != CAP) since_fall <= since_fall + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) !rst_n |=> !win_active && !sr_load); // R1
    AST_OPEN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_active) |-> (char_idx == 0 && dot_idx == 0)); // R2
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        win_active |-> (dot_idx < DOTS && char_idx < CHARS)); // R4
    AST_LOAD_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |-> (win_active && dot_idx == DOTS - 1)); // R6
    AST_LOAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |=> (!win_active || dot_idx == 0)); // R6
    AST_LAST_CHAR_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_load && char_idx == CHARS - 1) |=> !win_active); // R7
    AST_LINE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        win_active |-> since_fall < LINE); // R8
    AST_FALL_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hflb) |=> !win_active); // R9
endmodule

bind hosd_htiming hosd_chk #(.LINE(LINE), .DOTS(DOTS), .CHARS(CHARS)) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .hflb (hflb),
    .win_active (win_active),
    .char_idx (char_idx),
    .dot_idx (dot_idx),
    .sr_load (sr_load)
);

// File: tb/tb_hosd_htiming.sv
`timescale 1ns/1ps
module tb_hosd_htiming;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hflb = 1'b0;
    logic [4:0] hpos = '0;
    logic       dbl_wide = 1'b0;
    logic       win_active;
    logic [4:0] char_idx;
    logic [3:0] dot_idx;
    logic       sr_load;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hosd_htiming dut (
        .clk (clk),
        .rst_n (rst_n),
        .hflb (hflb),
        .hpos (hpos),
        .dbl_wide (dbl_wide),
        .win_active (win_active),
        .char_idx (char_idx),
        .dot_idx (dot_idx),
        .sr_load (sr_load)
    );

    // {hpos, dbl, expected window length}
    localparam logic [15:0] VEC [7] = '{
        {5'd0,  1'b0, 10'd288},
        {5'd5,  1'b0, 10'd288},
        {5'd6,  1'b0, 10'd287},
        {5'd31, 1'b0, 10'd137},
        {5'd0,  1'b1, 10'd323},
        {5'd10, 1'b1, 10'd263},
        {5'd31, 1'b1, 10'd137}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // starts a line with a one-clock flyback pulse, then checks ncyc clocks
    task automatic run_line(input int hp, input bit dw, input int len, input int ncyc,
                            input int chg_at, input int hp2, input bit dw2);
        int d;
        d = hp * 6 + 61;
        @(posedge clk); #1;
        hflb = 1'b1; hpos = 5'(hp); dbl_wide = dw;
        @(posedge clk); #1;
        hflb = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            bit ea;
            int o;
            @(posedge clk); #1;
            ea = (k >= d) && (k < d + len);
            o = k - d;
            check(k < d ? "R2 window" : (k < 384 ? "R7 window" : "R10 window"),
                  int'(win_active), int'(ea));
            if (ea) begin
                if (dw) begin
                    check("R5 dot", int'(dot_idx), (o / 2) % 12);
                    check("R5 char", int'(char_idx), o / 24);
                    check("R6 load", int'(sr_load), int'(o % 24 == 23));
                end else begin
                    check("R4 dot", int'(dot_idx), o % 12);
                    check("R4 char", int'(char_idx), o / 12);
                    check("R6 load", int'(sr_load), int'(o % 12 == 11));
                end
            end else begin
                check("R6 load idle", int'(sr_load), 0);
            end
            if (k == chg_at) begin
                hpos = 5'(hp2);
                dbl_wide = dw2;
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset active", int'(win_active), 0);
        check("R1 reset load", int'(sr_load), 0);
        rst_n = 1'b1;
        repeat (20) @(posedge clk);
        #1;
        check("R1 no line yet", int'(win_active), 0);
        check("R1 no line load", int'(sr_load), 0);

        // table walk: R2 R4 R5 R6 R7 R8
        foreach (VEC[i]) begin
            run_line(int'(VEC[i][15:11]), VEC[i][10], int'(VEC[i][9:0]), 400, -1, 0, 1'b0);
        end

        // R3: settings changed mid-line are ignored
        run_line(0, 1'b0, 288, 400, 10, 20, 1'b1);
        run_line(3, 1'b1, 323 - 18, 400, 70, 0, 1'b0);

        // R9: abort an open window at k=150, then restart with new settings
        run_line(0, 1'b0, 288, 150, -1, 0, 1'b0);
        check("R9 open before abort", int'(win_active), 1);
        run_line(2, 1'b0, 288, 400, -1, 0, 1'b0);

        // R10: stays blank long after close, low and then high flyback level
        run_line(0, 1'b0, 288, 900, -1, 0, 1'b0);
        hflb = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(posedge clk); #1;
            check("R10 high level", int'(win_active), 0);
        end
        hflb = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule